// File: doc/BRIEF.md
# Window Fetch Address Generator

This block produces the memory read requests that pull one overlay window's pixels out of a framebuffer, one line at a time, for each frame. Software gives it the first byte of the visible rectangle, the number of bytes to read on each line, the number of bytes to step over between lines, an end address that limits the fetch, a pixel format code and the framebuffer width in pixels. It then issues bursts on a valid/ready request port. Each burst carries a byte address and a length in 4-byte words.

The burst size follows the pixel format. It drops to a short 4-word burst when the framebuffer is narrow. The last burst of a line is cut to what is left of that line. A frame-start pulse takes a fresh copy of the configuration and begins again from the start address. A done flag marks the end of the frame's fetch. Requests are only offered while the window enable input is high.

All addresses and byte counts are multiples of 4. The configuration is captured on the frame-start pulse.

Top module: `wfetch_addr_gen`

## Requirements
- R1: Format code 0 (8-bit palette) uses bursts of 8 words when the framebuffer is at least 128 pixels wide.
- R2: Format codes 1 and 2 (16-bit) and codes 3 and 4 (32-bit) use bursts of 16 words when the framebuffer is at least 128 pixels wide.
- R3: Format codes 5, 6 and 7 are unknown. They are handled as 32-bit unpacked colour with 16-word bursts.
- R4: A framebuffer narrower than 128 pixels forces 4-word bursts for every format code. At exactly 128 pixels the format's own size applies.
- R5: Each line fetches exactly the configured line byte count, starting at the line's first address. The bursts are consecutive. A burst is shortened to the words left in its line and never crosses the line end. Lengths are in 4-byte words.
- R6: Each line starts at the previous line's start plus the line byte count plus the skip byte count.
- R7: For every request, address + 4*length is no greater than the end address. A line that reaches the end address is cut there. No line starts at or beyond the end address.
- R8: A frame-start pulse captures the configuration and clears the done flag. The next request is at the start address, even when the pulse arrives in the middle of a frame.
- R9: No request is offered while the window enable is low, and the fetch position is kept. A request that is stalled by a low ready keeps its address.
- R10: The done flag rises in the cycle after the final burst of the frame is accepted and stays high until the next frame-start pulse. No request is offered while it is high. A frame with a zero line byte count, or with the start at or past the end address, is done at once.
- R11: During and after reset, no request is offered and the done flag is low until a frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| win_en | input | 1 | Window enable; requests are gated by it |
| cfg_base | input | ADDR_W | Byte address of the first visible pixel |
| cfg_line_bytes | input | ADDR_W | Bytes fetched per line |
| cfg_skip_bytes | input | ADDR_W | Bytes stepped over between lines |
| cfg_end | input | ADDR_W | End address of the fetch (exclusive) |
| cfg_fmt | input | 3 | Pixel format code |
| cfg_fb_width | input | FBW_W | Framebuffer width in pixels |
| req_ready | input | 1 | Memory side accepts the request |
| req_valid | output | 1 | Request offered |
| req_addr | output | ADDR_W | Burst byte address |
| req_len | output | 5 | Burst length in words |
| frame_done | output | 1 | All lines of the frame have been requested |

## Verification
On every cycle, the assertions check the following:
- A request never passes the end address or its line end.
- A burst is never longer than the size chosen for the frame.
- A stalled request keeps its address.
- Nothing is offered while the window is disabled or once the frame is done.

The bench scenarios are needed for the rest:
- the exact address and length of every burst across format codes and widths, including the boundary at 128 pixels;
- the stride from one line to the next;
- truncation at the end address;
- a restart in the middle of a frame;
- holding off under a low enable, and the zero-length frame.

// File: rtl/wfetch_pkg.sv
package wfetch_pkg;

   localparam int unsigned BLEN_W = 5;

   typedef enum logic [2:0] {
      PF_PAL8    = 3'd0,
      PF_RGB1555 = 3'd1,
      PF_RGB565  = 3'd2,
      PF_XRGB    = 3'd3,
      PF_ARGB    = 3'd4
   } pix_fmt_e;

   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_RUN  = 1'b1
   } walk_state_e;

   // Natural burst length in words for a format code; unknown codes
   // fall back to the 32-bit unpacked case.
   function automatic logic [BLEN_W-1:0] fmt_burst_words(input logic [2:0] code);
      logic [BLEN_W-1:0] w;
      case (code)
         PF_PAL8:    w = BLEN_W'(8);
         PF_RGB1555: w = BLEN_W'(16);
         PF_RGB565:  w = BLEN_W'(16);
         PF_XRGB:    w = BLEN_W'(16);
         PF_ARGB:    w = BLEN_W'(16);
         default:    w = BLEN_W'(16);
      endcase
      return w;
   endfunction

endpackage

// File: rtl/wfetch_burst_sel.sv
module wfetch_burst_sel
   import wfetch_pkg::*;
#(
   parameter int unsigned FBW_W     = 16,
   parameter int unsigned NARROW_PX = 128,
   parameter int unsigned SHORT_LEN = 4
) (
   input  logic [2:0]        fmt,
   input  logic [FBW_W-1:0]  fb_width,
   output logic [BLEN_W-1:0] burst_words
);

   localparam logic [FBW_W-1:0] NARROW_LIM = FBW_W'(NARROW_PX);

   logic [BLEN_W-1:0] natural_len;

   always_comb natural_len = fmt_burst_words(fmt);

   generate
      if (NARROW_PX > 0) begin : g_narrow_fallback
         always_comb begin
            if (fb_width < NARROW_LIM) burst_words = BLEN_W'(SHORT_LEN);
            else                       burst_words = natural_len;
         end
      end else begin : g_format_only
         logic unused_fbw;
         assign unused_fbw  = ^fb_width;
         assign burst_words = natural_len;
      end
   endgenerate

   always_comb begin
      AST_BURST_LEGAL: assert (burst_words == 5'd4 || burst_words == 5'd8 || burst_words == 5'd16); // R4
   end

endmodule

// File: rtl/wfetch_clip.sv
module wfetch_clip
   import wfetch_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [BLEN_W-1:0] burst_words,
   input  logic [ADDR_W-1:0] line_rem_words,
   input  logic [ADDR_W-1:0] end_rem_words,
   output logic [BLEN_W-1:0] len_words
);

   localparam int unsigned PAD = ADDR_W - BLEN_W;

   logic [ADDR_W-1:0] burst_ext;
   logic [ADDR_W-1:0] step1;

   always_comb begin
      burst_ext = {{PAD{1'b0}}, burst_words};
      step1     = (line_rem_words < burst_ext) ? line_rem_words : burst_ext;
      if (end_rem_words < step1) len_words = end_rem_words[BLEN_W-1:0];
      else                       len_words = step1[BLEN_W-1:0];
   end

   always_comb begin
      AST_CLIP_BOUND: assert (len_words <= burst_words); // R5
   end

endmodule

// File: rtl/wfetch_walker.sv
module wfetch_walker
   import wfetch_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              win_en,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] line_bytes,
   input  logic [ADDR_W-1:0] skip_bytes,
   input  logic [ADDR_W-1:0] end_addr,
   input  logic [BLEN_W-1:0] burst_in,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BLEN_W-1:0] req_len,
   output logic              frame_done
);

   localparam int unsigned PAD = ADDR_W - BLEN_W - 2;

   walk_state_e       state_q;
   logic [ADDR_W-1:0] addr_q, line_start_q, line_end_q, end_q, stride_q, lbytes_q;
   logic [BLEN_W-1:0] burst_q;
   logic              done_q;

   logic [ADDR_W-1:0] line_rem_w, end_rem_w, nxt_addr, nxt_line;
   logic [BLEN_W-1:0] len;
   logic              accept, line_over;

   always_comb begin
      line_rem_w = (line_end_q - addr_q) >> 2;
      end_rem_w  = (end_q - addr_q) >> 2;
   end

   wfetch_clip #(.ADDR_W(ADDR_W)) i_clip (
      .burst_words   (burst_q),
      .line_rem_words(line_rem_w),
      .end_rem_words (end_rem_w),
      .len_words     (len)
   );

   always_comb begin
      req_valid = (state_q == WS_RUN) && win_en && (len != '0) && !done_q;
      req_addr  = addr_q;
      req_len   = len;
      accept    = req_valid && req_ready;
      nxt_addr  = addr_q + {{PAD{1'b0}}, len, 2'b00};
      nxt_line  = line_start_q + stride_q;
      line_over = (nxt_addr >= line_end_q) || (nxt_addr >= end_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= WS_IDLE;
         addr_q       <= '0;
         line_start_q <= '0;
         line_end_q   <= '0;
         end_q        <= '0;
         stride_q     <= '0;
         lbytes_q     <= '0;
         burst_q      <= '0;
         done_q       <= 1'b0;
      end else if (frame_start) begin
         burst_q      <= burst_in;
         end_q        <= end_addr;
         stride_q     <= line_bytes + skip_bytes;
         lbytes_q     <= line_bytes;
         addr_q       <= base;
         line_start_q <= base;
         line_end_q   <= base + line_bytes;
         if (line_bytes == '0 || base >= end_addr) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
         end else begin
            state_q <= WS_RUN;
            done_q  <= 1'b0;
         end
      end else if (state_q == WS_RUN) begin
         if (len == '0) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
         end else if (accept) begin
            if (line_over) begin
               if (nxt_line >= end_q || nxt_addr >= end_q) begin
                  state_q <= WS_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  addr_q       <= nxt_line;
                  line_start_q <= nxt_line;
                  line_end_q   <= nxt_line + lbytes_q;
               end
            end else begin
               addr_q <= nxt_addr;
            end
         end
      end
   end

   assign frame_done = done_q;

   AST_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (nxt_addr <= end_q)); // R7
   AST_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (nxt_addr <= line_end_q)); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !frame_start) |=> $stable(req_addr)); // R9
   AST_GATED_BY_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |-> !req_valid); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !req_valid); // R10
   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_start) |=> frame_done); // R10

endmodule

// File: rtl/wfetch_addr_gen.sv
module wfetch_addr_gen
   import wfetch_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned FBW_W     = 16,
   parameter int unsigned NARROW_PX = 128,
   parameter int unsigned SHORT_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              win_en,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_line_bytes,
   input  logic [ADDR_W-1:0] cfg_skip_bytes,
   input  logic [ADDR_W-1:0] cfg_end,
   input  logic [2:0]        cfg_fmt,
   input  logic [FBW_W-1:0]  cfg_fb_width,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [4:0]        req_len,
   output logic              frame_done
);

   generate
      if (ADDR_W < 12 || ADDR_W > 64) begin : g_bad_addr_w
         $error("wfetch_addr_gen: ADDR_W out of range");
      end
      if (FBW_W < 8 || FBW_W > 16) begin : g_bad_fbw_w
         $error("wfetch_addr_gen: FBW_W out of range");
      end
      if (NARROW_PX >= (1 << FBW_W)) begin : g_bad_narrow
         $error("wfetch_addr_gen: NARROW_PX exceeds width range");
      end
      if (SHORT_LEN == 0 || SHORT_LEN > 16) begin : g_bad_short
         $error("wfetch_addr_gen: SHORT_LEN out of range");
      end
   endgenerate

   logic [BLEN_W-1:0] burst_sel;

   wfetch_burst_sel #(
      .FBW_W    (FBW_W),
      .NARROW_PX(NARROW_PX),
      .SHORT_LEN(SHORT_LEN)
   ) i_burst_sel (
      .fmt        (cfg_fmt),
      .fb_width   (cfg_fb_width),
      .burst_words(burst_sel)
   );

   wfetch_walker #(.ADDR_W(ADDR_W)) i_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .win_en     (win_en),
      .base       (cfg_base),
      .line_bytes (cfg_line_bytes),
      .skip_bytes (cfg_skip_bytes),
      .end_addr   (cfg_end),
      .burst_in   (burst_sel),
      .req_ready  (req_ready),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .frame_done (frame_done)
   );

   AST_NO_REQ_IN_RESET: assert property (@(posedge clk)
      !rst_n |-> !req_valid); // R11

endmodule

// File: tb/test_wfetch_addr_gen.sv
module test_wfetch_addr_gen;

   typedef struct packed {
      logic [2:0]  fmt;
      logic [15:0] fbw;
      logic [31:0] base;
      logic [31:0] lb;
      logic [31:0] sk;
      logic [31:0] endv;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 16'd200, 32'h1000, 32'd100, 32'd100, 32'h1258},
      '{3'd2, 16'd160, 32'h2000, 32'd80,  32'd240, 32'h2280},
      '{3'd3, 16'd128, 32'h3000, 32'd80,  32'd432, 32'h3400},
      '{3'd3, 16'd127, 32'h4000, 32'd40,  32'd468, 32'h43F8},
      '{3'd6, 16'd256, 32'h5000, 32'd128, 32'd896, 32'h5400},
      '{3'd4, 16'd200, 32'h6000, 32'd200, 32'd600, 32'h6384},
      '{3'd1, 16'd64,  32'h7000, 32'd16,  32'd112, 32'h7180}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        win_en = 1'b1;
   logic [31:0] cfg_base = '0, cfg_line_bytes = '0, cfg_skip_bytes = '0, cfg_end = '0;
   logic [2:0]  cfg_fmt = '0;
   logic [15:0] cfg_fb_width = '0;
   logic        req_ready = 1'b0;
   logic        req_valid;
   logic [31:0] req_addr;
   logic [4:0]  req_len;
   logic        frame_done;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   wfetch_addr_gen i_wfetch_addr_gen (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .win_en(win_en),
      .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes),
      .cfg_skip_bytes(cfg_skip_bytes), .cfg_end(cfg_end), .cfg_fmt(cfg_fmt),
      .cfg_fb_width(cfg_fb_width), .req_ready(req_ready), .req_valid(req_valid),
      .req_addr(req_addr), .req_len(req_len), .frame_done(frame_done)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string vtag(input int i);
      case (i)
         0: return "R1";
         1: return "R2";
         2: return "R4 at-limit";
         3: return "R4 narrow";
         4: return "R3";
         5: return "R7";
         default: return "R4 narrow16";
      endcase
   endfunction

   task automatic load_cfg(input vec_t v);
      cfg_fmt        = v.fmt;
      cfg_fb_width   = v.fbw;
      cfg_base       = v.base;
      cfg_line_bytes = v.lb;
      cfg_skip_bytes = v.sk;
      cfg_end        = v.endv;
   endtask

   task automatic run_vec(input vec_t v, input string tag, input bit stall);
      logic [31:0] ea [64];
      logic [4:0]  el [64];
      int          ne, ng, burst;
      longint      ls, a, lenw;
      logic [31:0] prev_addr;
      bit          stalled_prev;
      // expected burst list from the requirements
      burst = (v.fmt == 3'd0) ? 8 : 16;
      if (v.fbw < 16'd128) burst = 4;
      ne = 0;
      ls = longint'(v.base);
      while (ls < longint'(v.endv)) begin
         a = ls;
         while (a < ls + longint'(v.lb) && a < longint'(v.endv)) begin
            lenw = burst;
            if ((ls + longint'(v.lb) - a) / 4 < lenw) lenw = (ls + longint'(v.lb) - a) / 4;
            if ((longint'(v.endv) - a) / 4 < lenw) lenw = (longint'(v.endv) - a) / 4;
            ea[ne] = a[31:0];
            el[ne] = lenw[4:0];
            ne++;
            a = a + lenw * 4;
         end
         ls = ls + longint'(v.lb) + longint'(v.sk);
      end
      @(negedge clk);
      load_cfg(v);
      req_ready   = 1'b0;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start  = 1'b0;
      ng           = 0;
      stalled_prev = 1'b0;
      prev_addr    = '0;
      for (int c = 0; c < 600; c++) begin
         bit rdy;
         if (frame_done) break;
         rdy = stall ? ((c % 3) != 0) : 1'b1;
         req_ready = rdy;
         if (stalled_prev)
            check(req_addr == prev_addr, {tag, " R9 stalled address hold"}, req_addr, prev_addr);
         if (req_valid && rdy) begin
            if (ng < ne) begin
               check(req_addr == ea[ng], {tag, " R5 R6 burst addr"}, req_addr, ea[ng]);
               check(req_len == el[ng], {tag, " R5 burst len"}, 32'(req_len), 32'(el[ng]));
            end
            ng++;
         end
         stalled_prev = req_valid && !rdy;
         prev_addr    = req_addr;
         @(negedge clk);
      end
      req_ready = 1'b0;
      check(ng == ne, {tag, " R6 burst count"}, 32'(ng), 32'(ne));
      check(frame_done == 1'b1, {tag, " R10 done raised"}, 32'(frame_done), 32'd1);
      check(req_valid == 1'b0, {tag, " R10 quiet when done"}, 32'(req_valid), 32'd0);
      @(negedge clk);
      check(frame_done == 1'b1, {tag, " R10 done held"}, 32'(frame_done), 32'd1);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      vec_t v;
      // R11: reset state
      repeat (3) @(negedge clk);
      check(req_valid == 1'b0, "R11 no request in reset", 32'(req_valid), 32'd0);
      check(frame_done == 1'b0, "R11 done low in reset", 32'(frame_done), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(req_valid == 1'b0, "R11 no request before frame", 32'(req_valid), 32'd0);
      check(frame_done == 1'b0, "R11 done low before frame", 32'(frame_done), 32'd0);

      // vector table
      for (int i = 0; i < NV; i++) run_vec(VECS[i], vtag(i), (i % 2) == 1);

      // R8: restart in the middle of a frame
      v = VECS[0];
      @(negedge clk);
      load_cfg(v);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      req_ready   = 1'b1;
      repeat (3) @(negedge clk);
      req_ready   = 1'b0;
      cfg_base    = 32'h8000;
      cfg_end     = 32'h8258;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      check(req_addr == 32'h8000, "R8 restart address", req_addr, 32'h8000);
      check(req_valid == 1'b1, "R8 restart offers request", 32'(req_valid), 32'd1);
      check(frame_done == 1'b0, "R8 done cleared", 32'(frame_done), 32'd0);

      // R10: done clears on the next frame start after a finished frame
      req_ready = 1'b1;
      for (int c = 0; c < 100 && !frame_done; c++) @(negedge clk);
      req_ready = 1'b0;
      check(frame_done == 1'b1, "R10 done after restarted frame", 32'(frame_done), 32'd1);

      // R9: window disabled holds off requests and keeps the position
      v = VECS[1];
      @(negedge clk);
      load_cfg(v);
      win_en      = 1'b0;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      req_ready   = 1'b1;
      begin
         bit seen = 1'b0;
         for (int c = 0; c < 10; c++) begin
            if (req_valid) seen = 1'b1;
            @(negedge clk);
         end
         check(seen == 1'b0, "R9 no request while disabled", 32'(seen), 32'd0);
      end
      req_ready = 1'b0;
      win_en    = 1'b1;
      #1;
      check(req_valid == 1'b1, "R9 request after enable", 32'(req_valid), 32'd1);
      check(req_addr == v.base, "R9 position kept while disabled", req_addr, v.base);
      req_ready = 1'b1;
      for (int c = 0; c < 100 && !frame_done; c++) @(negedge clk);
      req_ready = 1'b0;

      // R10: zero line byte count finishes at once
      @(negedge clk);
      load_cfg(VECS[2]);
      cfg_line_bytes = '0;
      frame_start    = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      check(frame_done == 1'b1, "R10 empty frame done", 32'(frame_done), 32'd1);
      check(req_valid == 1'b0, "R10 empty frame quiet", 32'(req_valid), 32'd0);

      // R7: start at the end address finishes at once
      @(negedge clk);
      load_cfg(VECS[3]);
      cfg_end     = cfg_base;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      check(frame_done == 1'b1, "R7 start at end done", 32'(frame_done), 32'd1);
      check(req_valid == 1'b0, "R7 start at end quiet", 32'(req_valid), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule